// File: doc/BRIEF.md
# Multi-Voice Slot Sequencer

This block sets the slot timing for a sample player that serves many voices from one engine. It divides the input clock by four into a slow phase, E, and runs every voice through two sample fetches, one per E period. It then issues a voice-update strobe. At that strobe the voice's scaled output is written into the output slot that the voice's channel field selects. A voice counter steps through the active voices and returns to zero at the end of each frame. A host access window is opened once per E period, during the E-high phase.

Per-voice state is held outside this block. The surrounding logic presents the current voice's values on the inputs, indexed by `voice_idx`: the accumulator integer part, the channel field, the filter output and the volume. From these the block produces the memory address and bank for each fetch and stores the scaled result in the output slots. Memory contents and the rest of the signal path are not part of this block.

Top module: `voice_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase, the fetch index, the voice counter, the host pending flag and every output slot are cleared. In reset, `e_pin`, `voice_upd`, `frame_end` and `host_ack` are low, `voice_idx` is 0 and `slot_bus` is all zero.
- R2: `e_pin` repeats a four-cycle pattern: low for two clock cycles, then high for two. The first cycle after reset is the first low cycle.
- R3: `mem_rd` is high only in the first cycle of each E-low phase. During every cycle `mem_addr` equals `acc_int + fetch_idx`, taken modulo 2^16, and `mem_bank` equals bits [2:0] of `chan_sel`.
- R4: `fetch_idx` is 0 for the first E period of a voice and 1 for the second. `voice_upd` is a single-cycle pulse in the second E-low cycle of that second period, and `fetch_idx` is 0 again in the next cycle. Each voice therefore lasts 8 clock cycles.
- R5: After every update `voice_idx` moves up by one. When the updated voice is at or above the limit L = min(24, `active_cnt`), `voice_idx` goes to 0 instead, and `frame_end` pulses in the same cycle as that `voice_upd`.
- R6: An `active_cnt` above 24 acts as 24, so a frame never holds more than 25 voices.
- R7: `chan_we` is zero except during `voice_upd`. During `voice_upd` it is one-hot, with bit `chan_sel` set, and that slot (bits [16*k+15:16*k] of `slot_bus` for slot k) takes the new value at the following clock edge. All other slots keep their values.
- R8: The value written is computed as follows. `filt_in` is read as a signed 16-bit number and shifted right arithmetically by 3. The result is multiplied by the unsigned 12-bit `vol_in`, shifted right arithmetically by 12, and kept to its low 16 bits.
- R9: `host_ack` is high only in the last E-high cycle, and only when a request is pending. A request is held pending from a cycle in which `host_req` is sampled high. The pending flag is cleared at the E falling edge, so a request seen only in the last E-high cycle is dropped.
- R10: If `active_cnt` is lowered below the current voice, the next update wraps the counter to 0 with `frame_end`, without first running up to 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| active_cnt | input | 5 | Number of the last active voice (capped at 24) |
| acc_int | input | 16 | Accumulator integer part of the current voice |
| chan_sel | input | 4 | Channel field of the current voice |
| filt_in | input | 16 | Filter output of the current voice (signed) |
| vol_in | input | 12 | Volume of the current voice |
| host_req | input | 1 | Host access request |
| e_pin | output | 1 | E phase (clock / 4) |
| voice_idx | output | 5 | Current voice |
| fetch_idx | output | 1 | Fetch number within the voice (0 or 1) |
| voice_upd | output | 1 | Voice-update strobe |
| frame_end | output | 1 | End-of-frame strobe |
| mem_rd | output | 1 | Sample fetch strobe |
| mem_bank | output | 3 | Sample memory bank |
| mem_addr | output | 16 | Sample memory address |
| chan_we | output | 16 | Per-slot write enable, one-hot |
| slot_bus | output | 256 | All output slots, slot k at bits [16k+15:16k] |
| host_ack | output | 1 | Host access grant |

## Verification
A cycle model runs alongside the design. Every output is compared in every cycle while the per-voice inputs take new pseudo-random values each cycle. From time to time the filter input is forced to its most negative value with full volume, which tells a correct arithmetic shift and a correct unsigned volume apart from a logical shift or a signed volume. Active counts of 0, 3, 24 and 31 separate the off-by-one wrap point from the cap. A count lowered in mid-frame shows that the wrap compares with "at or above" rather than "equal". A dense, irregular host request pattern falls on every phase, which exposes a grant in the wrong sub-cycle and a missed clear at the falling edge.

// File: rtl/vs_pkg.sv
// Package for the voice sequencer: E-phase encoding and default sizes.
package vs_pkg;
    // Four clock phases per E period; E is high during the HI phases.
    typedef enum logic [1:0] {
        PH_LO0 = 2'd0,
        PH_LO1 = 2'd1,
        PH_HI0 = 2'd2,
        PH_HI1 = 2'd3
    } phase_t;

    localparam int unsigned DEF_MAX_VOICES = 25;
    localparam int unsigned DEF_VOICE_W    = 5;
    localparam int unsigned DEF_ADDR_W     = 16;
    localparam int unsigned DEF_CA_W       = 4;
    localparam int unsigned DEF_BANK_W     = 3;
    localparam int unsigned DEF_SMP_W      = 16;
    localparam int unsigned DEF_VOL_W      = 12;
    localparam int unsigned DEF_SLOT_W     = 16;
endpackage

// File: rtl/vs_phase_gen.sv
// Phase generator: splits the input clock into four phases per E period.
// Assumes: a free-running clock; after reset the first cycle is PH_LO0.
module vs_phase_gen
    import vs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t ph,
    output logic   e_pin
);
    // Step the phase every clock and start again from PH_LO0 on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_LO0;
        else        ph <= phase_t'(ph + 2'd1);
    end

    // E is high in the second half of the period.
    assign e_pin = ph[1];
endmodule

// File: rtl/vs_slot_counter.sv
// Slot counter: keeps the fetch index and the voice number.
// Assumes: updates happen on the PH_LO1 edge of a voice's second E period.
module vs_slot_counter
    import vs_pkg::*;
#(
    parameter int unsigned MAX_VOICES = DEF_MAX_VOICES,
    parameter int unsigned VOICE_W    = DEF_VOICE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  phase_t             ph,
    input  logic [VOICE_W-1:0] active_cnt,
    output logic [VOICE_W-1:0] voice_idx,
    output logic               fetch_idx,
    output logic               voice_upd,
    output logic               frame_end
);
    localparam logic [VOICE_W-1:0] LAST_V = VOICE_W'(MAX_VOICES - 1);

    logic [VOICE_W-1:0] limit;

    // Active count capped at the last voice the engine supports.
    assign limit     = (active_cnt > LAST_V) ? LAST_V : active_cnt;
    assign voice_upd = (ph == PH_LO1) && fetch_idx;
    assign frame_end = voice_upd && (voice_idx >= limit);

    // Alternate the fetch index, then advance or wrap the voice at update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_idx <= 1'b0;
            voice_idx <= '0;
        end else if (ph == PH_LO1) begin
            if (fetch_idx) begin
                fetch_idx <= 1'b0;
                voice_idx <= frame_end ? '0 : voice_idx + 1'b1;
            end else begin
                fetch_idx <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vs_host_window.sv
// Host window: a request is held until the E falling edge and granted
// in the last E-high cycle.
// Assumes: the host keeps its request up until it sees host_ack.
module vs_host_window
    import vs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t ph,
    input  logic   host_req,
    output logic   host_ack
);
    logic pending;

    // Grant in the last E-high cycle if a request is waiting.
    assign host_ack = pending && (ph == PH_HI1);

    // Collect requests and drop them at every E falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)             pending <= 1'b0;
        else if (ph == PH_HI1)  pending <= 1'b0;
        else                    pending <= pending | host_req;
    end
endmodule

// File: rtl/vs_out_stage.sv
// Output stage: scales the voice output and writes it into the slot
// named by its channel field.
// Assumes: the inputs describe the voice being updated in the wr_en cycle.
module vs_out_stage
    import vs_pkg::*;
#(
    parameter int unsigned CA_W   = DEF_CA_W,
    parameter int unsigned SMP_W  = DEF_SMP_W,
    parameter int unsigned VOL_W  = DEF_VOL_W,
    parameter int unsigned SLOT_W = DEF_SLOT_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CA_W-1:0]               chan_sel,
    input  logic [SMP_W-1:0]              filt_in,
    input  logic [VOL_W-1:0]              vol_in,
    output logic [(1<<CA_W)-1:0]          chan_we,
    output logic [(1<<CA_W)*SLOT_W-1:0]   slot_bus
);
    localparam int unsigned NSLOT  = 1 << CA_W;
    localparam int unsigned PRE_SH = 3;
    localparam int unsigned POST_SH = VOL_W;
    localparam int unsigned PW     = SMP_W + VOL_W + 1;

    logic signed [SMP_W-1:0] fsig;
    logic signed [SMP_W-1:0] f_sh;
    logic signed [PW-1:0]    prod;
    logic [SLOT_W-1:0]       new_val;

    // Signed sample, shifted down, times the unsigned volume.
    assign fsig    = filt_in;
    assign f_sh    = fsig >>> PRE_SH;
    assign prod    = $signed({{(PW-SMP_W){f_sh[SMP_W-1]}}, f_sh})
                   * $signed({{(PW-VOL_W){1'b0}}, vol_in});
    assign new_val = SLOT_W'(prod >>> POST_SH);

    // Write enable for the addressed slot only.
    assign chan_we = wr_en ? (NSLOT'(1) << chan_sel) : '0;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        // Hold slot k, load it when its write enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n)         slot_bus[k*SLOT_W +: SLOT_W] <= '0;
            else if (chan_we[k]) slot_bus[k*SLOT_W +: SLOT_W] <= new_val;
        end
    end
endmodule

// File: rtl/voice_sequencer.sv
// Voice sequencer top: E-phase timing, two fetches per voice, voice and
// frame stepping, host window and the output slots.
// Assumes: outside storage presents the values of voice voice_idx.
module voice_sequencer
    import vs_pkg::*;
#(
    parameter int unsigned MAX_VOICES = DEF_MAX_VOICES,
    parameter int unsigned VOICE_W    = DEF_VOICE_W,
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned CA_W       = DEF_CA_W,
    parameter int unsigned BANK_W     = DEF_BANK_W,
    parameter int unsigned SMP_W      = DEF_SMP_W,
    parameter int unsigned VOL_W      = DEF_VOL_W,
    parameter int unsigned SLOT_W     = DEF_SLOT_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [VOICE_W-1:0]             active_cnt,
    input  logic [ADDR_W-1:0]              acc_int,
    input  logic [CA_W-1:0]                chan_sel,
    input  logic [SMP_W-1:0]               filt_in,
    input  logic [VOL_W-1:0]               vol_in,
    input  logic                           host_req,
    output logic                           e_pin,
    output logic [VOICE_W-1:0]             voice_idx,
    output logic                           fetch_idx,
    output logic                           voice_upd,
    output logic                           frame_end,
    output logic                           mem_rd,
    output logic [BANK_W-1:0]              mem_bank,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [(1<<CA_W)-1:0]           chan_we,
    output logic [(1<<CA_W)*SLOT_W-1:0]    slot_bus,
    output logic                           host_ack
);
    phase_t ph;

    vs_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (ph),
        .e_pin (e_pin)
    );

    vs_slot_counter #(
        .MAX_VOICES (MAX_VOICES),
        .VOICE_W    (VOICE_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph         (ph),
        .active_cnt (active_cnt),
        .voice_idx  (voice_idx),
        .fetch_idx  (fetch_idx),
        .voice_upd  (voice_upd),
        .frame_end  (frame_end)
    );

    vs_host_window u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph       (ph),
        .host_req (host_req),
        .host_ack (host_ack)
    );

    vs_out_stage #(
        .CA_W   (CA_W),
        .SMP_W  (SMP_W),
        .VOL_W  (VOL_W),
        .SLOT_W (SLOT_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (voice_upd),
        .chan_sel (chan_sel),
        .filt_in  (filt_in),
        .vol_in   (vol_in),
        .chan_we  (chan_we),
        .slot_bus (slot_bus)
    );

    // Fetch strobe at the start of E-low; address is integer part + fetch.
    assign mem_rd   = (ph == PH_LO0);
    assign mem_addr = acc_int + ADDR_W'(fetch_idx);
    assign mem_bank = chan_sel[BANK_W-1:0];
endmodule

// File: rtl/vs_checker.sv
// Checker for the voice sequencer; it watches the top-level ports only.
module vs_checker #(
    parameter int unsigned VOICE_W = 5,
    parameter int unsigned NSLOT   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               e_pin,
    input logic [VOICE_W-1:0] voice_idx,
    input logic               fetch_idx,
    input logic               voice_upd,
    input logic               frame_end,
    input logic               mem_rd,
    input logic [NSLOT-1:0]   chan_we,
    input logic               host_ack
);
    p_e_high_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_pin) |=> e_pin);
    p_e_low_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_pin) |=> !e_pin);
    p_rd_in_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !e_pin);
    p_upd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        voice_upd |=> !voice_upd);
    p_upd_second_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        voice_upd |-> (fetch_idx && !e_pin));
    p_fetch_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        voice_upd |=> !fetch_idx);
    p_voice_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !voice_upd |=> $stable(voice_idx));
    p_voice_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (voice_upd && !frame_end) |=> (voice_idx == $past(voice_idx) + 1'b1));
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (voice_idx == '0));
    p_end_with_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> voice_upd);
    p_cap_24_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (voice_upd && voice_idx == VOICE_W'(24)) |-> frame_end);
    p_we_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_we));
    p_we_only_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_we != '0) |-> voice_upd);
    p_ack_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> e_pin);
    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
endmodule

bind voice_sequencer vs_checker #(
    .VOICE_W (VOICE_W),
    .NSLOT   (1 << CA_W)
) u_vs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .e_pin     (e_pin),
    .voice_idx (voice_idx),
    .fetch_idx (fetch_idx),
    .voice_upd (voice_upd),
    .frame_end (frame_end),
    .mem_rd    (mem_rd),
    .chan_we   (chan_we),
    .host_ack  (host_ack)
);

// File: tb/tb_voice_sequencer.sv
// Bench: a cycle model runs next to the design and every output is
// compared at each falling clock edge.
module tb_voice_sequencer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   active_cnt = '0;
    logic [15:0]  acc_int = '0;
    logic [3:0]   chan_sel = '0;
    logic [15:0]  filt_in = '0;
    logic [11:0]  vol_in = '0;
    logic         host_req = 1'b0;
    logic         e_pin, fetch_idx, voice_upd, frame_end, mem_rd, host_ack;
    logic [4:0]   voice_idx;
    logic [2:0]   mem_bank;
    logic [15:0]  mem_addr;
    logic [15:0]  chan_we;
    logic [255:0] slot_bus;

    voice_sequencer dut (
        .clk(clk), .rst_n(rst_n), .active_cnt(active_cnt), .acc_int(acc_int),
        .chan_sel(chan_sel), .filt_in(filt_in), .vol_in(vol_in),
        .host_req(host_req), .e_pin(e_pin), .voice_idx(voice_idx),
        .fetch_idx(fetch_idx), .voice_upd(voice_upd), .frame_end(frame_end),
        .mem_rd(mem_rd), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .chan_we(chan_we), .slot_bus(slot_bus), .host_ack(host_ack)
    );

    always #4 clk = ~clk;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    bit          done   = 0;
    logic [31:0] lf     = 32'h1234_5678;
    int          req_pct = 25;
    string       vsect  = "R5";

    int          m_ph, m_fidx, m_voice, m_pend;
    logic [15:0] m_slot [16];

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lim(input int a);
        return (a > 24) ? 24 : a;
    endfunction

    // R8 arithmetic, worked out in plain integers.
    function automatic logic [15:0] scale(input logic [15:0] f, input logic [11:0] v);
        int fi, f3, p, r;
        fi = int'($signed(f));
        f3 = fi >>> 3;
        p  = f3 * int'({20'd0, v});
        r  = p >>> 12;
        return r[15:0];
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic drive_inputs();
        logic [31:0] b;
        lf = nxt(lf);
        b  = nxt(lf);
        acc_int  = lf[15:0];
        chan_sel = lf[19:16];
        filt_in  = b[15:0];
        vol_in   = b[27:16];
        if (b[31:29] == 3'd0) begin
            filt_in = 16'h8000;
            vol_in  = 12'hFFF;
        end
        host_req = (int'(lf[26:20]) % 100) < req_pct;
    endtask

    task automatic step_model();
        if (m_ph == 1 && m_fidx == 1) begin
            m_slot[chan_sel] = scale(filt_in, vol_in);
            if (m_voice >= lim(int'(active_cnt))) m_voice = 0;
            else                                  m_voice++;
            m_fidx = 0;
        end else if (m_ph == 1) begin
            m_fidx = 1;
        end
        m_pend = (m_ph == 3) ? 0 : (m_pend | int'(host_req));
        m_ph   = (m_ph + 1) % 4;
    endtask

    task automatic compare();
        logic        e_x, upd_x, fe_x, ack_x;
        logic [15:0] we_x, addr_x;
        logic [255:0] slots_x;
        e_x    = (m_ph >= 2);
        upd_x  = (m_ph == 1 && m_fidx == 1);
        fe_x   = upd_x && (m_voice >= lim(int'(active_cnt)));
        ack_x  = (m_pend != 0) && (m_ph == 3);
        we_x   = upd_x ? (16'd1 << chan_sel) : 16'd0;
        addr_x = acc_int + 16'(m_fidx);
        for (int k = 0; k < 16; k++) slots_x[k*16 +: 16] = m_slot[k];
        chk("R2", "e_pin", 256'(e_pin), 256'(e_x));
        chk("R3", "mem_rd", 256'(mem_rd), 256'(m_ph == 0));
        chk("R3", "mem_addr", 256'(mem_addr), 256'(addr_x));
        chk("R3", "mem_bank", 256'(mem_bank), 256'(chan_sel[2:0]));
        chk("R4", "fetch_idx", 256'(fetch_idx), 256'(m_fidx));
        chk("R4", "voice_upd", 256'(voice_upd), 256'(upd_x));
        chk(vsect, "voice_idx", 256'(voice_idx), 256'(m_voice));
        chk(vsect, "frame_end", 256'(frame_end), 256'(fe_x));
        chk("R7", "chan_we", 256'(chan_we), 256'(we_x));
        chk("R8", "slot_bus", slot_bus, slots_x);
        chk("R9", "host_ack", 256'(host_ack), 256'(ack_x));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            drive_inputs();
            step_model();
        end
    endtask

    // R1: hold reset for two edges, check cleared state, release.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        m_ph = 0; m_fidx = 0; m_voice = 0; m_pend = 0;
        for (int k = 0; k < 16; k++) m_slot[k] = '0;
        chk("R1", "voice_idx", 256'(voice_idx), 256'(0));
        chk("R1", "fetch_idx", 256'(fetch_idx), 256'(0));
        chk("R1", "e_pin", 256'(e_pin), 256'(0));
        chk("R1", "voice_upd", 256'(voice_upd), 256'(0));
        chk("R1", "frame_end", 256'(frame_end), 256'(0));
        chk("R1", "host_ack", 256'(host_ack), 256'(0));
        chk("R1", "slot_bus", slot_bus, 256'(0));
        rst_n = 1'b1;
        drive_inputs();
        step_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        active_cnt = 5'd3;
        do_reset();
        run(80);                       // R5: short frame of four voices
        active_cnt = 5'd0;
        run(48);                       // R5: single voice, frame_end every update
        active_cnt = 5'd24;
        run(25 * 8 + 24);              // R5: full 25-voice frame
        vsect = "R6";
        active_cnt = 5'd31;
        run(25 * 8 + 24);              // R6: count above the cap
        vsect = "R5";
        active_cnt = 5'd10;
        do_reset();                    // R1: slots written above are cleared
        run(8 * 8 + 2);                // voice 8 reached, just after its start
        vsect = "R10";
        active_cnt = 5'd3;
        run(48);                       // R10: lowered count wraps at next update
        vsect = "R5";
        req_pct = 70;
        active_cnt = 5'd1;
        run(96);                       // R9: dense host requests on every phase
        req_pct = 5;
        active_cnt = 5'd6;
        run(120);                      // R9: sparse, isolated requests
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule